// File: doc/BRIEF.md
# End-of-Write Status Reporter

This block sits on the read path of a byte-wide nonvolatile memory. It decides what the data pins show while an internal write or erase cycle runs. Software learns that the cycle has finished by reading the part, not through a ready pin. Two indicators are carried on ordinary reads:

- Bit 7 returns the complement of bit 7 of the last byte loaded, until the write is done.
- Bit 6 alternates from one read to the next for as long as the cycle lasts.

When the cycle ends, the block runs a settling window of a fixed number of clocks. In this window bit 7 already carries true data. Bits 5 to 0 carry a defined marker pattern, which is the array value XOR 3Fh. After the window, array data passes straight to the bus. The write controller supplies a busy level and an erase qualifier. The array supplies the byte being read. Chip-enable and output-enable arrive active low and are sampled on the system clock.

Top module: `eow_status_reporter`

## Requirements
- R1: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low. While `dq_oe` is low, `dq_out` is 00h.
- R2: During a write cycle, bit 7 of a read equals the inverse of bit 7 of `last_byte`, and bits 5..0 equal `array_data[5:0]`.
- R3: The first read in any write or erase cycle returns 1 on bit 6.
- R4: During a cycle, bit 6 flips once after each read completes. A read is complete when the enable condition of R1 is released. While one read is held active, bit 6 stays stable.
- R5: For SETTLE_CYC clocks after `busy` falls, a read returns the settle pattern. Bit 7 is true data: `last_byte[7]` after a write, `array_data[7]` after an erase. Bit 6 is `array_data[6]`. Bits 5..0 are `array_data[5:0]` XOR 3Fh.
- R6: Outside any cycle and settle window, a read returns `array_data` unchanged.
- R7: During an erase cycle (`erase` high when `busy` rises), bit 7 reads 0, bit 6 is the toggle bit, and bits 5..0 equal `array_data[5:0]`.
- R8: Status reporting begins on the first clock edge that samples `busy` high after it was low.
- R9: A rising `busy` during a settle window starts a new cycle at once and presets the toggle bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Internal write/erase cycle running |
| erase | input | 1 | Qualifies the cycle starting with `busy` as an erase |
| last_byte | input | 8 | Last byte loaded into the page buffer |
| array_data | input | 8 | Array read data for the addressed byte |
| dq_out | output | 8 | Data driven toward the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Suppose the phase register holds a wrong value. The first read after the fault then shows raw array data where status belongs, or the reverse, so the error is visible within one read. Suppose instead the toggle register misses a preset or a flip. Bit 6 then breaks its expected alternation on the next completed read. A settle counter that is off by one moves the switch to raw data one clock early or late, and a read held active across the window sees it. The bench keeps its own read count and clock count and predicts each of these values.

// File: rtl/eow_pkg.sv
package eow_pkg;

  typedef enum logic [1:0] {
    PH_READY  = 2'd0,
    PH_WRITE  = 2'd1,
    PH_ERASE  = 2'd2,
    PH_SETTLE = 2'd3
  } eow_phase_e;

  localparam logic [5:0] SETTLE_MASK = 6'h3F;

  // Byte returned while a write cycle is running.
  function automatic logic [7:0] write_status(input logic [7:0] last,
                                              input logic [7:0] arr,
                                              input logic       tgl);
    return {~last[7], tgl, arr[5:0]};
  endfunction

  // Byte returned while an erase cycle is running.
  function automatic logic [7:0] erase_status(input logic [7:0] arr,
                                              input logic       tgl);
    return {1'b0, tgl, arr[5:0]};
  endfunction

  // Byte returned inside the settle window.
  function automatic logic [7:0] settle_pattern(input logic       true_b7,
                                                input logic [7:0] arr);
    return {true_b7, arr[6], arr[5:0] ^ SETTLE_MASK};
  endfunction

endpackage

// File: rtl/eow_phase_tracker.sv
module eow_phase_tracker
  import eow_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       erase,
  output eow_phase_e phase,
  output logic       was_erase,
  output logic       start_evt
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign start_evt = busy && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      phase     <= PH_READY;
      cnt_q     <= '0;
      was_erase <= 1'b0;
    end else begin
      busy_q <= busy;
      if (start_evt) begin
        phase     <= erase ? PH_ERASE : PH_WRITE;
        was_erase <= erase;
        cnt_q     <= '0;
      end else begin
        unique case (phase)
          PH_WRITE, PH_ERASE: if (!busy) begin
            phase <= PH_SETTLE;
            cnt_q <= CNT_LOAD;
          end
          PH_SETTLE: begin
            if (cnt_q == '0) phase <= PH_READY;
            else             cnt_q <= cnt_q - 1'b1;
          end
          default: phase <= PH_READY;
        endcase
      end
    end
  end

  AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !erase) |=> (phase == PH_WRITE)); // R8
  AST_ERASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && erase) |=> (phase == PH_ERASE)); // R7
  AST_SETTLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE && cnt_q == '0 && !start_evt) |=> (phase == PH_READY)); // R5
  AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE && start_evt) |=> (phase != PH_SETTLE)); // R9

endmodule

// File: rtl/eow_toggle_gen.sv
module eow_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic in_cycle,
  input  logic rd_en,
  output logic tgl_q
);
  logic rd_en_q;
  logic read_done;

  assign read_done = rd_en_q && !rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      tgl_q   <= 1'b1;
    end else begin
      rd_en_q <= rd_en;
      if (start_evt)                  tgl_q <= 1'b1;
      else if (in_cycle && read_done) tgl_q <= ~tgl_q;
    end
  end

  AST_TGL_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> tgl_q); // R3
  AST_TGL_HELD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && rd_en_q && rd_en) |=> $stable(tgl_q)); // R4

endmodule

// File: rtl/eow_bus_mux.sv
module eow_bus_mux
  import eow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  eow_phase_e phase,
  input  logic       was_erase,
  input  logic       rd_en,
  input  logic       tgl,
  input  logic [7:0] last_byte,
  input  logic [7:0] array_data,
  output logic [7:0] dq_out
);
  logic [7:0] sel_byte;
  logic       true_b7;

  assign true_b7 = was_erase ? array_data[7] : last_byte[7];

  always_comb begin
    unique case (phase)
      PH_WRITE:  sel_byte = write_status(last_byte, array_data, tgl);
      PH_ERASE:  sel_byte = erase_status(array_data, tgl);
      PH_SETTLE: sel_byte = settle_pattern(true_b7, array_data);
      default:   sel_byte = array_data;
    endcase
  end

  assign dq_out = rd_en ? sel_byte : 8'h00;

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (dq_out == 8'h00)); // R1
  AST_WRITE_B7_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && phase == PH_WRITE) |-> (dq_out[7] != last_byte[7])); // R2
  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && phase == PH_READY) |-> (dq_out == array_data)); // R6

endmodule

// File: rtl/eow_status_reporter.sv
module eow_status_reporter
  import eow_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       busy,
  input  logic       erase,
  input  logic [7:0] last_byte,
  input  logic [7:0] array_data,
  output logic [7:0] dq_out,
  output logic       dq_oe
);
  eow_phase_e phase;
  logic       was_erase;
  logic       start_evt;
  logic       in_cycle;
  logic       rd_en;
  logic       tgl;

  assign rd_en    = !ce_n && !oe_n;
  assign dq_oe    = rd_en;
  assign in_cycle = (phase == PH_WRITE) || (phase == PH_ERASE);

  eow_phase_tracker #(.SETTLE_CYC(SETTLE_CYC)) phase_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .erase(erase),
    .phase(phase), .was_erase(was_erase), .start_evt(start_evt)
  );

  eow_toggle_gen toggle_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
    .in_cycle(in_cycle), .rd_en(rd_en), .tgl_q(tgl)
  );

  eow_bus_mux mux_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .was_erase(was_erase),
    .rd_en(rd_en), .tgl(tgl), .last_byte(last_byte),
    .array_data(array_data), .dq_out(dq_out)
  );

  AST_OE_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!dq_oe && dq_out == 8'h00)); // R1

endmodule

// File: tb/eow_status_reporter_tb_top.sv
module eow_status_reporter_tb_top;
  localparam int CLK_PER = 10;
  localparam int SETTLE  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0, erase = 1'b0;
  logic [7:0] last_byte = 8'h00, array_data = 8'h00;
  logic [7:0] dq_out;
  logic       dq_oe;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  eow_status_reporter #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .erase(erase), .last_byte(last_byte), .array_data(array_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_write(input logic [7:0] l, input logic [7:0] a, input logic t);
    return {!l[7], t, a[5:0]};
  endfunction

  function automatic logic [7:0] exp_settle(input logic b7, input logic [7:0] a);
    return {b7, a[6], ~a[5:0]};
  endfunction

  // One complete read held for three clocks, bit 6 checked stable (R4).
  task automatic read_cycle(input string req, input logic [7:0] exp);
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      nclk(1);
      chk(req, {dq_oe, dq_out}, {1'b1, exp});
    end
    ce_n = 1'b1; oe_n = 1'b1;
    nclk(1);
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic t;
    nclk(3);
    chk("R1 reset", {dq_oe, dq_out}, 9'h000);
    rst_n = 1'b1;
    nclk(1);
    // R1: both enables are needed
    ce_n = 1'b0; array_data = 8'h5A; nclk(1);
    chk("R1 oe high", {dq_oe, dq_out}, 9'h000);
    ce_n = 1'b1; oe_n = 1'b0; nclk(1);
    chk("R1 ce high", {dq_oe, dq_out}, 9'h000);
    oe_n = 1'b1;
    // R6: pass-through sweep
    for (int v = 0; v < 256; v += 17) begin
      array_data = 8'(v);
      ce_n = 1'b0; oe_n = 1'b0; nclk(1);
      chk("R6 ready pass", {dq_oe, dq_out}, {1'b1, 8'(v)});
      ce_n = 1'b1; oe_n = 1'b1; nclk(1);
    end
    // Write cycles over a sweep of loaded bytes
    for (int s = 0; s < 16; s++) begin
      last_byte  = 8'(s * 37 + 5);
      array_data = 8'(s * 91 + 3);
      // R8: read held across the busy rise
      ce_n = 1'b0; oe_n = 1'b0;
      busy = 1'b1;
      nclk(1);
      chk("R8 start edge", {1'b0, dq_out}, {1'b0, exp_write(last_byte, array_data, 1'b1)});
      ce_n = 1'b1; oe_n = 1'b1; nclk(1);
      // that held read completed: next read shows 0
      t = 1'b0;
      for (int r = 0; r < 5; r++) begin
        read_cycle("R2 R3 R4 write status", exp_write(last_byte, array_data, t));
        t = !t;
      end
      // R5/R6: settle window then raw data, read held
      ce_n = 1'b0; oe_n = 1'b0;
      busy = 1'b0;
      for (int k = 1; k <= SETTLE; k++) begin
        nclk(1);
        chk("R5 settle write", {1'b0, dq_out}, {1'b0, exp_settle(last_byte[7], array_data)});
      end
      nclk(1);
      chk("R6 after settle", {1'b0, dq_out}, {1'b0, array_data});
      ce_n = 1'b1; oe_n = 1'b1; nclk(1);
    end
    // R7: erase cycle
    for (int s = 0; s < 4; s++) begin
      array_data = 8'(s * 77 + 200);
      erase = 1'b1; busy = 1'b1; nclk(2);
      t = 1'b1;
      for (int r = 0; r < 4; r++) begin
        read_cycle("R7 R3 erase status", {1'b0, t, array_data[5:0]});
        t = !t;
      end
      busy = 1'b0; erase = 1'b0;
      ce_n = 1'b0; oe_n = 1'b0;
      for (int k = 1; k <= SETTLE; k++) begin
        nclk(1);
        chk("R5 settle erase", {1'b0, dq_out}, {1'b0, exp_settle(array_data[7], array_data)});
      end
      nclk(1);
      chk("R6 after erase", {1'b0, dq_out}, {1'b0, array_data});
      ce_n = 1'b1; oe_n = 1'b1; nclk(1);
    end
    // R9: restart inside the settle window
    last_byte = 8'h80; array_data = 8'h33;
    busy = 1'b1; nclk(2);
    read_cycle("R9 first", exp_write(last_byte, array_data, 1'b1));
    busy = 1'b0; nclk(2);
    busy = 1'b1; nclk(1);
    read_cycle("R9 restart preset", exp_write(last_byte, array_data, 1'b1));
    read_cycle("R9 restart flip", exp_write(last_byte, array_data, 1'b0));
    busy = 1'b0; nclk(SETTLE + 2);
    read_cycle("R6 final", array_data);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule